// File: doc/BRIEF.md
# Dual-Slope PWM Timer with Two Compare Channels

This block is an up/down timer for centre-aligned pulse-width modulation. An 8-bit counter climbs from 0 to its top value 255, turns, descends to 0 and turns again, so every value between the two ends is visited once on each slope. Two compare channels watch the counter. On each crossing of a channel's compare value the channel drives its waveform pin high or low, depending on the slope and on the channel's output mode. The pulses are symmetric about the instant the counter sits at 0.

The counter moves only on cycles where the tick enable input is high. An external prescaler therefore sets the PWM rate at the clock frequency divided by the tick divisor times 510. Compare values are double-buffered: a write lands in a holding register, and it becomes active when the counter is at its top value. At the bottom of each sweep the pin is forced to the level that comes before the up-slope match. This keeps the waveform correct after compare-value changes, and also after a counter preset that jumps over a match. An overflow flag marks the arrival at 0. A sticky match flag per channel marks equality with the active compare value. A preset port can overwrite the counter at any time.

Top module: `pcpwm_timer`

## Requirements
- R1: After reset both waveform pins, the overflow flag and both match flags are low, and the counter is at 0 heading upwards, so the first overflow comes on the 510th tick.
- R2: The counter visits 0,1,…,255,254,…,1,0,1,… with one step per tick, a period of 510 ticks. The overflow flag is set on the tick that moves the counter from 1 to 0, and a one-cycle pulse on ovf_clr clears it.
- R3: With tick_en low the counter does not move and no overflow is raised. With tick_en high every second cycle the period is 1020 clock cycles.
- R4: Mode code 2 (non-inverted): the pin is driven low by an up-slope match and high by a down-slope match, giving 2×C high ticks per period for compare value C.
- R5: Mode code 3 (inverted): the pin levels are the reverse of code 2, giving 2×C low ticks per period.
- R6: A compare value of 0 gives a pin held low in code 2 and high in code 3. A compare value of 255 gives a pin held high in code 2 and low in code 3.
- R7: A compare write goes to a buffer, and it becomes active only on the tick where the counter is at 255.
- R8: On the tick at counter value 0, in codes 2 and 3, the pin is forced to its pre-up-match level (code 2: high when the active compare value is non-zero, low otherwise), even when the down-slope match was skipped.
- R9: Channel A with mode code 1 and wave_toggle_en high inverts its pin on every channel A match, giving two edges per period for a compare value between 1 and 254.
- R10: Mode code 0 on either channel, code 1 on channel B, and code 1 on channel A with wave_toggle_en low each hold the pin low.
- R11: A channel's match flag is set on a tick where the counter equals that channel's active compare value. It stays set until a one-cycle pulse on the channel's clear input, and a set in the same cycle wins over a clear.
- R12: A cnt_load pulse puts cnt_load_val into the counter at the next edge whether or not tick_en is high. In a load cycle no compare action takes place: no flag set, no pin change, no buffer transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick_en | input | 1 | Counter advance enable from prescaler |
| wave_toggle_en | input | 1 | Permits toggle behaviour for mode code 1 on channel A |
| mode_a | input | 2 | Channel A output mode (0 off, 1 toggle, 2 non-inverted, 3 inverted) |
| mode_b | input | 2 | Channel B output mode (1 treated as off) |
| cmp_a_wr | input | 1 | Write strobe for channel A compare buffer |
| cmp_a_val | input | 8 | Channel A compare value |
| cmp_b_wr | input | 1 | Write strobe for channel B compare buffer |
| cmp_b_val | input | 8 | Channel B compare value |
| cnt_load | input | 1 | Counter preset strobe |
| cnt_load_val | input | 8 | Counter preset value |
| ovf_clr | input | 1 | Clears overflow flag |
| match_a_clr | input | 1 | Clears channel A match flag |
| match_b_clr | input | 1 | Clears channel B match flag |
| wave_a | output | 1 | Channel A waveform |
| wave_b | output | 1 | Channel B waveform |
| ovf_flag | output | 1 | Counter reached 0 |
| match_a_flag | output | 1 | Channel A compare match seen |
| match_b_flag | output | 1 | Channel B compare match seen |

## Verification
The assertions assume a steady clock under a synchronous reset. They assume that the mode inputs change only between runs, not in the middle of a match cycle, and that every counter value moves by one step per tick unless a preset overrides it. The stimulus changes modes and compare values only while the waveforms are allowed to settle for two full periods before any measurement. It applies presets as isolated pulses, or as one held burst that is followed by free running, and it drives the tick enable from one generator with three fixed patterns: always, every other cycle, and never.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

    // Output behaviour codes for a compare channel
    typedef enum logic [1:0] {
        CMP_OFF    = 2'd0,
        CMP_TOGGLE = 2'd1,
        CMP_NONINV = 2'd2,
        CMP_INV    = 2'd3
    } cmp_mode_e;

    // Sweep direction of the counter
    typedef enum logic {
        DIR_UP   = 1'b0,
        DIR_DOWN = 1'b1
    } dir_e;

endpackage

// File: rtl/pcpwm_sweep_counter.sv
module pcpwm_sweep_counter
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         load_en,
    input  logic [W-1:0] load_val,
    input  logic         ovf_clr,
    output logic [W-1:0] cnt,
    output dir_e         dir,
    output logic         step,
    output logic         ovf_flag
);

    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;
    localparam logic [W-1:0] ONE = W'(1);

    typedef struct packed {
        logic [W-1:0] cnt;
        dir_e         dir;
        logic         ovf;
    } state_t;

    state_t s_d, s_q;

    always_comb begin
        s_d  = s_q;
        step = tick_en && !load_en;
        if (load_en) begin
            s_d.cnt = load_val;
            if (load_val == TOP)      s_d.dir = DIR_DOWN;
            else if (load_val == BOT) s_d.dir = DIR_UP;
        end else if (tick_en) begin
            if (s_q.cnt == TOP) begin
                s_d.cnt = TOP - ONE;
                s_d.dir = DIR_DOWN;
            end else if (s_q.cnt == BOT) begin
                s_d.cnt = ONE;
                s_d.dir = DIR_UP;
            end else if (s_q.dir == DIR_UP) begin
                s_d.cnt = s_q.cnt + ONE;
            end else begin
                s_d.cnt = s_q.cnt - ONE;
            end
        end
        if (ovf_clr) s_d.ovf = 1'b0;
        if (step && s_q.cnt == ONE && s_q.dir == DIR_DOWN) s_d.ovf = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{cnt: BOT, dir: DIR_UP, ovf: 1'b0};
        else        s_q <= s_d;
    end

    assign cnt      = s_q.cnt;
    assign dir      = s_q.dir;
    assign ovf_flag = s_q.ovf;

    // R2: a free tick moves the counter by exactly one
    a_r2_single_step: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_en && !load_en) |=> (s_q.cnt == $past(s_q.cnt) + ONE) || (s_q.cnt == $past(s_q.cnt) - ONE));

    // R3: no tick, no load -> counter holds
    a_r3_hold_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick_en && !load_en) |=> $stable(s_q.cnt));

    // R12: preset value appears at the next edge
    a_r12_load_value: assert property (@(posedge clk) disable iff (!rst_n)
        load_en |=> (s_q.cnt == $past(load_val)));

    // R2: overflow only rises from a descending step off value 1
    a_r2_ovf_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.ovf) |-> $past(tick_en && !load_en && s_q.cnt == ONE && s_q.dir == DIR_DOWN));

endmodule

// File: rtl/pcpwm_compare_unit.sv
module pcpwm_compare_unit
    import pcpwm_pkg::*;
#(
    parameter int W          = 8,
    parameter bit HAS_TOGGLE = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         step,
    input  logic [W-1:0] cnt,
    input  dir_e         dir,
    input  logic         toggle_en,
    input  logic [1:0]   mode,
    input  logic         buf_wr,
    input  logic [W-1:0] buf_val,
    input  logic         flag_clr,
    output logic         wave,
    output logic         flag
);

    localparam logic [W-1:0] TOP = '1;
    localparam logic [W-1:0] BOT = '0;

    typedef struct packed {
        logic [W-1:0] buf_v;
        logic [W-1:0] act;
        logic         pin;
        logic         flag;
    } state_t;

    state_t    s_d, s_q;
    cmp_mode_e m;
    logic      at_top, at_bot, hit, falling;

    assign m       = cmp_mode_e'(mode);
    assign at_top  = (cnt == TOP);
    assign at_bot  = (cnt == BOT);
    assign hit     = (cnt == s_q.act);
    assign falling = at_top || (dir == DIR_DOWN && !at_bot);

    always_comb begin
        logic lvl;
        s_d = s_q;
        lvl = 1'b0;
        if (buf_wr) s_d.buf_v = buf_val;
        if (step && at_top) s_d.act = s_q.buf_v;
        if (flag_clr) s_d.flag = 1'b0;
        if (step && hit) s_d.flag = 1'b1;
        unique case (m)
            CMP_NONINV, CMP_INV: begin
                if (step && (at_bot || hit)) begin
                    if (at_bot) lvl = (s_q.act != BOT);
                    else        lvl = falling;
                    s_d.pin = lvl ^ (m == CMP_INV);
                end
            end
            CMP_TOGGLE: begin
                if (HAS_TOGGLE && toggle_en) begin
                    if (step && hit) s_d.pin = ~s_q.pin;
                end else begin
                    s_d.pin = 1'b0;
                end
            end
            default: s_d.pin = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '{buf_v: BOT, act: BOT, pin: 1'b0, flag: 1'b0};
        else        s_q <= s_d;
    end

    assign wave = s_q.pin;
    assign flag = s_q.flag;

    // R7: active compare value only changes on a tick at the top
    a_r7_act_stable: assert property (@(posedge clk) disable iff (!rst_n)
        !(step && at_top) |=> $stable(s_q.act));

    // R11: a flag rise needs a counted equality
    a_r11_flag_source: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(s_q.flag) |-> $past(step && cnt == s_q.act));

    // R10: disconnected code keeps the pin low
    a_r10_off_low: assert property (@(posedge clk) disable iff (!rst_n)
        (m == CMP_OFF) |=> !s_q.pin);

    // R12: no pin change without a counted step
    a_r12_pin_needs_step: assert property (@(posedge clk) disable iff (!rst_n)
        (!step && m != CMP_OFF && m != CMP_TOGGLE) |=> $stable(s_q.pin));

    generate
        if (!HAS_TOGGLE) begin : g_no_toggle
            // R10: toggle code is disconnected on a channel without toggle
            a_r10_b_code1_low: assert property (@(posedge clk) disable iff (!rst_n)
                (m == CMP_TOGGLE) |=> !s_q.pin);
        end
    endgenerate

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
    import pcpwm_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick_en,
    input  logic         wave_toggle_en,
    input  logic [1:0]   mode_a,
    input  logic [1:0]   mode_b,
    input  logic         cmp_a_wr,
    input  logic [W-1:0] cmp_a_val,
    input  logic         cmp_b_wr,
    input  logic [W-1:0] cmp_b_val,
    input  logic         cnt_load,
    input  logic [W-1:0] cnt_load_val,
    input  logic         ovf_clr,
    input  logic         match_a_clr,
    input  logic         match_b_clr,
    output logic         wave_a,
    output logic         wave_b,
    output logic         ovf_flag,
    output logic         match_a_flag,
    output logic         match_b_flag
);

    localparam int NCH = 2;

    logic [W-1:0]   cnt;
    dir_e           dir;
    logic           step;
    logic [1:0]     ch_mode [NCH];
    logic           ch_wr   [NCH];
    logic [W-1:0]   ch_val  [NCH];
    logic           ch_clr  [NCH];
    logic [NCH-1:0] ch_wave;
    logic [NCH-1:0] ch_flag;

    assign ch_mode[0] = mode_a;      assign ch_mode[1] = mode_b;
    assign ch_wr[0]   = cmp_a_wr;    assign ch_wr[1]   = cmp_b_wr;
    assign ch_val[0]  = cmp_a_val;   assign ch_val[1]  = cmp_b_val;
    assign ch_clr[0]  = match_a_clr; assign ch_clr[1]  = match_b_clr;

    pcpwm_sweep_counter #(.W(W)) i_counter (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick_en  (tick_en),
        .load_en  (cnt_load),
        .load_val (cnt_load_val),
        .ovf_clr  (ovf_clr),
        .cnt      (cnt),
        .dir      (dir),
        .step     (step),
        .ovf_flag (ovf_flag)
    );

    generate
        for (genvar c = 0; c < NCH; c++) begin : g_ch
            pcpwm_compare_unit #(.W(W), .HAS_TOGGLE(c == 0)) i_cmp (
                .clk       (clk),
                .rst_n     (rst_n),
                .step      (step),
                .cnt       (cnt),
                .dir       (dir),
                .toggle_en (wave_toggle_en),
                .mode      (ch_mode[c]),
                .buf_wr    (ch_wr[c]),
                .buf_val   (ch_val[c]),
                .flag_clr  (ch_clr[c]),
                .wave      (ch_wave[c]),
                .flag      (ch_flag[c])
            );
        end
    endgenerate

    assign wave_a       = ch_wave[0];
    assign wave_b       = ch_wave[1];
    assign match_a_flag = ch_flag[0];
    assign match_b_flag = ch_flag[1];

endmodule

// File: tb/test_pcpwm_timer.sv
module test_pcpwm_timer;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       tick_en;
    logic       wave_toggle_en;
    logic [1:0] mode_a, mode_b;
    logic       cmp_a_wr, cmp_b_wr, cnt_load;
    logic [7:0] cmp_a_val, cmp_b_val, cnt_load_val;
    logic       ovf_clr, match_a_clr, match_b_clr;
    logic       wave_a, wave_b, ovf_flag, match_a_flag, match_b_flag;

    int n_chk  = 0;
    int n_fail = 0;
    int tick_mode = 0;   // 0 every cycle, 1 every other cycle, 2 never
    bit done = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    pcpwm_timer i_pcpwm_timer (
        .clk(clk), .rst_n(rst_n), .tick_en(tick_en), .wave_toggle_en(wave_toggle_en),
        .mode_a(mode_a), .mode_b(mode_b),
        .cmp_a_wr(cmp_a_wr), .cmp_a_val(cmp_a_val), .cmp_b_wr(cmp_b_wr), .cmp_b_val(cmp_b_val),
        .cnt_load(cnt_load), .cnt_load_val(cnt_load_val),
        .ovf_clr(ovf_clr), .match_a_clr(match_a_clr), .match_b_clr(match_b_clr),
        .wave_a(wave_a), .wave_b(wave_b), .ovf_flag(ovf_flag),
        .match_a_flag(match_a_flag), .match_b_flag(match_b_flag)
    );

    always @(negedge clk) begin
        if (!rst_n)              tick_en <= 1'b1;
        else if (tick_mode == 0) tick_en <= 1'b1;
        else if (tick_mode == 1) tick_en <= ~tick_en;
        else                     tick_en <= 1'b0;
    end

    typedef struct packed {
        logic [1:0] mode;
        logic [7:0] cmp;
        logic [9:0] hi;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{2'd2, 8'd0,   10'd0},   '{2'd2, 8'd1,   10'd2},   '{2'd2, 8'd128, 10'd256},
        '{2'd2, 8'd254, 10'd508}, '{2'd2, 8'd255, 10'd510},
        '{2'd3, 8'd0,   10'd510}, '{2'd3, 8'd1,   10'd508}, '{2'd3, 8'd128, 10'd254},
        '{2'd3, 8'd254, 10'd2},   '{2'd3, 8'd255, 10'd0}
    };

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr_cmp(input bit a, input bit b, input logic [7:0] v);
        cmp_a_wr = a; cmp_b_wr = b; cmp_a_val = v; cmp_b_val = v;
        @(negedge clk);
        cmp_a_wr = 1'b0; cmp_b_wr = 1'b0;
    endtask

    // clear overflow, then wait for its next rise; returns cycles counted
    task automatic sync_bottom(output int n);
        ovf_clr = 1'b1;
        @(negedge clk);
        ovf_clr = 1'b0;
        n = 1;
        while (!ovf_flag && n < 3000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic measure(input int len, output int hi_a, output int hi_b, output int edges_a);
        logic prev;
        hi_a = 0; hi_b = 0; edges_a = 0;
        prev = wave_a;
        for (int i = 0; i < len; i++) begin
            @(negedge clk);
            if (wave_a) hi_a++;
            if (wave_b) hi_b++;
            if (wave_a != prev) edges_a++;
            prev = wave_a;
        end
    endtask

    initial begin
        int n, ha, hb, ea;
        string tag;
        rst_n = 1'b0; wave_toggle_en = 1'b0; mode_a = 2'd2; mode_b = 2'd2;
        cmp_a_wr = 1'b0; cmp_b_wr = 1'b0; cmp_a_val = '0; cmp_b_val = '0;
        cnt_load = 1'b0; cnt_load_val = '0;
        ovf_clr = 1'b0; match_a_clr = 1'b0; match_b_clr = 1'b0;
        cyc(4);
        rst_n = 1'b1;

        // R1 reset state
        chk("R1 wave_a", wave_a, 0);
        chk("R1 wave_b", wave_b, 0);
        chk("R1 ovf", ovf_flag, 0);
        chk("R1 flags", {match_a_flag, match_b_flag}, 0);
        n = 0;
        while (!ovf_flag && n < 3000) begin
            @(negedge clk);
            n++;
        end
        chk("R1 first overflow tick", n, 510);

        // R2 period and clear
        sync_bottom(n);
        chk("R2 period", n, 510);

        // R3 half rate and stop
        tick_mode = 1;
        sync_bottom(n);
        sync_bottom(n);
        chk("R3 half-rate period", n, 1020);
        tick_mode = 2;
        cyc(2);
        ovf_clr = 1'b1; cyc(1); ovf_clr = 1'b0;
        cyc(600);
        chk("R3 no overflow while stopped", ovf_flag, 0);
        tick_mode = 0;
        cyc(2);

        // R4 R5 R6 duty table
        for (int v = 0; v < NV; v++) begin
            mode_a = VECS[v].mode; mode_b = VECS[v].mode;
            wr_cmp(1'b1, 1'b1, VECS[v].cmp);
            cyc(1100);
            measure(510, ha, hb, ea);
            if (VECS[v].cmp == 8'd0 || VECS[v].cmp == 8'd255) tag = "R6";
            else if (VECS[v].mode == 2'd2)                    tag = "R4";
            else                                              tag = "R5";
            chk({tag, " high ticks ch A"}, ha, int'(VECS[v].hi));
            chk({tag, " high ticks ch B"}, hb, int'(VECS[v].hi));
        end

        // R7 buffered compare
        mode_a = 2'd2;
        wr_cmp(1'b1, 1'b0, 8'd128);
        cyc(1100);
        sync_bottom(n);
        wr_cmp(1'b1, 1'b0, 8'd10);
        cyc(29);
        chk("R7 new value not yet active", wave_a, 1);
        cyc(1100);
        measure(510, ha, hb, ea);
        chk("R7 new value active after top", ha, 20);

        // R8 forced level at bottom after skipped match
        wr_cmp(1'b1, 1'b0, 8'd100);
        cyc(1100);
        sync_bottom(n);
        cyc(300);
        chk("R8 low on descent above compare", wave_a, 0);
        cnt_load = 1'b1; cnt_load_val = 8'd50; ovf_clr = 1'b1;
        cyc(1);
        cnt_load = 1'b0; ovf_clr = 1'b0;
        cyc(5);
        chk("R12 preset leaves pin alone", wave_a, 0);
        n = 0;
        while (!ovf_flag && n < 3000) begin
            @(negedge clk);
            n++;
        end
        cyc(2);
        chk("R8 forced high at bottom", wave_a, 1);

        // R9 toggle on channel A
        mode_a = 2'd1; wave_toggle_en = 1'b1;
        cyc(1100);
        measure(510, ha, hb, ea);
        chk("R9 toggle edges per period", ea, 2);

        // R10 disconnected cases
        wave_toggle_en = 1'b0;
        cyc(2);
        measure(510, ha, hb, ea);
        chk("R10 A code1 without toggle enable", ha, 0);
        wave_toggle_en = 1'b1; mode_b = 2'd1;
        cyc(2);
        measure(510, ha, hb, ea);
        chk("R10 B code1", hb, 0);
        mode_a = 2'd0;
        cyc(2);
        measure(510, ha, hb, ea);
        chk("R10 A code0", ha, 0);

        // R11 R12 flags and preset suppression
        wr_cmp(1'b0, 1'b1, 8'd100);
        cyc(1100);
        tick_mode = 2;
        cyc(2);
        cnt_load = 1'b1; cnt_load_val = 8'd10;
        cyc(1);
        cnt_load = 1'b0; match_b_clr = 1'b1;
        cyc(1);
        match_b_clr = 1'b0;
        chk("R11 flag cleared", match_b_flag, 0);
        tick_mode = 0;
        cnt_load = 1'b1; cnt_load_val = 8'd100;
        cyc(6);
        chk("R12 no match during preset", match_b_flag, 0);
        cnt_load = 1'b0;
        cyc(1);
        chk("R11 match sets flag", match_b_flag, 1);
        match_b_clr = 1'b1;
        cyc(1);
        match_b_clr = 1'b0;
        chk("R11 clear after match", match_b_flag, 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: got 0 expected 1 (run completed)");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

endmodule